// File: doc/BRIEF.md
# Triggered Fan Tachometer Measurement Unit

This unit times the tachometer output of up to sixteen fans. Software enables the channels it wants to watch and records, for each one, a 3-bit tag naming the PWM port that drives that fan. It also sets a shared tick divider. A measurement on one channel is started with a one-hot trigger word. The unit resynchronises the chosen tach line and waits for a rising edge. It then counts divided-clock ticks until the next rising edge and reports that count together with a done flag.

Software converts the count to speed as clock × 60 / (2 × count × tick divisor), which assumes two pulses per revolution. A reading of zero, or a saturated all-ones reading, stands for a stopped or missing fan. All access goes through a simple register write port and a combinational read port.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset every readable register returns 0, including the result word (done clear, count zero).
- R2: The control word at address 0 holds channel enables at bit 16+ch and reads 0 in bits [15:0]. The type word at address 1 holds the type enable in bit 0, the divider in [3:1], the mode in [5:4] and a 16-bit unit in [31:16], and reads 0 elsewhere.
- R3: Each channel's 3-bit source tag is split across two registers. Tag bits [1:0] sit at bits [2ch+1:2ch] of address 2. Tag bit 2 sits at bit 2ch of address 3, and the odd bits of address 3 read 0.
- R4: A measurement starts only on a 0-to-1 change of a channel's bit in the trigger register (address 4). Writing a 1 to a bit that already holds 1 starts nothing, so software must write 0 first.
- R5: A new trigger bit starts a measurement only if that channel's enable bit is set and the type enable bit is 1. Otherwise the result word stays unchanged.
- R6: When one write raises several eligible trigger bits, the lowest-numbered channel is measured.
- R7: Ticks occur every 4 << (2 × divider) clocks (4, 16, 64, ...) while a measurement runs, and never while idle.
- R8: The tach input passes through a two-flop synchroniser and rising-edge detector. The count is the number of ticks between two consecutive rising edges, which equals floor((P−1)/D) for a steady period of P clocks and tick divisor D.
- R9: The result word at address 5 carries the count in bits [CNT_W−1:0] and done in bit 31, with 0 elsewhere. It holds its value while done is set and no new start occurs.
- R10: If the count reaches all-ones before the closing edge (in either the waiting or the counting phase), the unit sets done and reports all-ones.
- R11: A start clears done and the count to 0 at once and may restart a measurement that is still in progress.
- R12: The mode and unit fields are stored only; they do not change the measured count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 ctrl, 1 type, 2 src low, 3 src high, 4 trigger) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address (5 = result) |
| rd_data | output | 32 | Combinational read data |
| tach_in | input | NCH | Asynchronous tach inputs, one per channel |

## Verification
Synthetic square waves of different periods on separate channels are measured at three divider settings. This separates the edge-to-edge counting from the tick-divider arithmetic, and a wrong divider shows up as a proportional error. A line held low separates saturation from a normal close, and triggers that combine disabled, enabled and already-set bits separate the priority rule from the rising-edge rule. A restart onto a different channel mid-measurement shows that the start path clears the previous state. Rewriting the mode and unit fields shows that they leave the count unchanged.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  // register addresses
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_TYPE  = 3'd1;
  localparam logic [2:0] A_SRCLO = 3'd2;
  localparam logic [2:0] A_SRCHI = 3'd3;
  localparam logic [2:0] A_TRIG  = 3'd4;
  localparam logic [2:0] A_RES   = 3'd5;

  // field layout of the control and type words
  localparam int EN_LSB   = 16;
  localparam int DIV_LSB  = 1;
  localparam int DIV_W    = 3;
  localparam int MODE_LSB = 4;
  localparam int MODE_W   = 2;
  localparam int UNIT_LSB = 16;
  localparam int UNIT_W   = 16;
  localparam int SRC_W    = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_CNT} meas_state_e;

  // clocks per tick for a divider code
  function automatic int unsigned tick_period(input int unsigned div);
    return 32'd4 << (2 * div);
  endfunction

  // prescaler width able to hold the largest period minus one
  function automatic int pre_width(input int div_w);
    return 2 + 2 * ((1 << div_w) - 1);
  endfunction
endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tach_in,
  output logic [NCH-1:0] tach_rise
);
  logic [NCH-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= tach_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign tach_rise = s2_q & ~s3_q;
endmodule

// File: rtl/tach_tick_gen.sv
module tach_tick_gen
  import fan_tach_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [DW-1:0] div,
  output logic          tick
);
  localparam int PRE_W = pre_width(DW);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim  = PRE_W'(tick_period(32'(div)) - 32'd1);
  assign tick = run & ~clr & (pre_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (run) pre_q <= tick ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/tach_meas_fsm.sv
module tach_meas_fsm
  import fan_tach_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int CNT_W = 20,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CH_W-1:0]  start_ch,
  input  logic [NCH-1:0]   tach_rise,
  input  logic             tick,
  output logic             clr_pre,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] result,
  output logic             sat_evt,
  output logic             fin_evt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  meas_state_e      state_q;
  logic [CH_W-1:0]  sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sel_rise;

  assign sel_rise = tach_rise[sel_q];
  assign busy     = (state_q != ST_IDLE);
  assign clr_pre  = start | ((state_q == ST_ARM) & sel_rise);
  assign sat_evt  = busy & ~start & ~sel_rise & tick & (cnt_q == CMAX - 1'b1);
  assign fin_evt  = (state_q == ST_CNT) & sel_rise & ~start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      cnt_q   <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else if (start) begin
      state_q <= ST_ARM;
      sel_q   <= start_ch;
      cnt_q   <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else if (busy) begin
      if (sel_rise) begin
        if (state_q == ST_ARM) begin
          state_q <= ST_CNT;
          cnt_q   <= '0;
        end else begin
          state_q <= ST_IDLE;
          done    <= 1'b1;
          result  <= cnt_q;
        end
      end else if (sat_evt) begin
        state_q <= ST_IDLE;
        done    <= 1'b1;
        result  <= CMAX;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import fan_tach_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int CNT_W = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [2:0]     rd_addr,
  output logic [31:0]    rd_data,
  input  logic [NCH-1:0] tach_in
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0]    ctrl_en_q;
  logic              type_en_q;
  logic [DIV_W-1:0]  div_q;
  logic [MODE_W-1:0] mode_q;
  logic [UNIT_W-1:0] unit_q;
  logic [NCH-1:0]    trig_q;
  logic [SRC_W-1:0]  src_q [NCH];
  logic [2*NCH-1:0]  src_lo_rd, src_hi_rd;

  logic [NCH-1:0]    cand;
  logic              start;
  logic [CH_W-1:0]   start_ch;
  logic [NCH-1:0]    tach_rise;
  logic              tick, clr_pre, busy, done, sat_evt, fin_evt;
  logic [CNT_W-1:0]  result;
  logic [31:0]       res_word;

  // control, type and trigger registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q <= '0;
      type_en_q <= 1'b0;
      div_q     <= '0;
      mode_q    <= '0;
      unit_q    <= '0;
      trig_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: ctrl_en_q <= wr_data[EN_LSB +: NCH];
        A_TYPE: begin
          type_en_q <= wr_data[0];
          div_q     <= wr_data[DIV_LSB +: DIV_W];
          mode_q    <= wr_data[MODE_LSB +: MODE_W];
          unit_q    <= wr_data[UNIT_LSB +: UNIT_W];
        end
        A_TRIG: trig_q <= wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  // per-channel source tags, split over two words
  for (genvar g = 0; g < NCH; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q[g] <= '0;
      else if (wr_en && wr_addr == A_SRCLO) src_q[g][1:0] <= wr_data[2*g +: 2];
      else if (wr_en && wr_addr == A_SRCHI) src_q[g][2]   <= wr_data[2*g];
    end
    assign src_lo_rd[2*g +: 2] = src_q[g][1:0];
    assign src_hi_rd[2*g +: 2] = {1'b0, src_q[g][2]};
  end

  // start: newly raised, enabled bits; lowest channel wins
  assign cand  = (wr_en && wr_addr == A_TRIG && type_en_q) ?
                 (wr_data[NCH-1:0] & ~trig_q & ctrl_en_q) : '0;
  assign start = |cand;

  always_comb begin
    start_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i]) start_ch = CH_W'(i);
    end
  end

  tach_sync_edge #(.NCH(NCH)) sync_i (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .tach_rise(tach_rise)
  );

  tach_tick_gen #(.DW(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .clr(clr_pre), .div(div_q), .tick(tick)
  );

  tach_meas_fsm #(.NCH(NCH), .CNT_W(CNT_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ch(start_ch),
    .tach_rise(tach_rise), .tick(tick), .clr_pre(clr_pre), .busy(busy),
    .done(done), .result(result), .sat_evt(sat_evt), .fin_evt(fin_evt)
  );

  assign res_word = {done, {(31-CNT_W){1'b0}}, result};

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = 32'(ctrl_en_q) << EN_LSB;
      A_TYPE:  rd_data = {unit_q, 10'b0, mode_q, div_q, type_en_q};
      A_SRCLO: rd_data = 32'(src_lo_rd);
      A_SRCHI: rd_data = 32'(src_hi_rd);
      A_TRIG:  rd_data = 32'(trig_q);
      A_RES:   rd_data = res_word;
      default: rd_data = '0;
    endcase
  end
endmodule

module fan_tach_meter_chk #(
  parameter int NCH   = 16,
  parameter int CNT_W = 20,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CH_W-1:0]  start_ch,
  input logic [NCH-1:0]   ctrl_en,
  input logic             type_en,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] result,
  input logic             tick,
  input logic             sat_evt,
  input logic             fin_evt
);
  // R5
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (type_en && ctrl_en[start_ch]));
  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && result == '0));
  // R11
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(start));
  // R10
  sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> (done && !busy && result == {CNT_W{1'b1}}));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result)));
  // R7
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tick);
  // R8
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (done && !busy));
endmodule

bind fan_tach_meter fan_tach_meter_chk #(.NCH(NCH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .start_ch(start_ch),
  .ctrl_en(ctrl_en_q), .type_en(type_en_q), .busy(busy), .done(done),
  .result(result), .tick(tick), .sat_evt(sat_evt), .fin_evt(fin_evt)
);

// File: tb/fan_tach_meter_tb_top.sv
module fan_tach_meter_tb_top;
  localparam int NCH   = 16;
  localparam int CNT_W = 10;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd5;
  logic [31:0] rd_data;
  logic [15:0] tach = '0;

  int checks = 0;
  int errs = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fan_tach_meter #(.NCH(NCH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tach_in(tach)
  );

  // ---------------- stimulus: square waves ----------------
  int hp [16];
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    for (int c = 0; c < 16; c++)
      tach[c] <= (hp[c] == 0) ? 1'b0 : 1'(((cyc / hp[c]) % 2));
  end

  // ---------------- behavioural reference model ----------------
  int m_state, m_pre, m_cnt, m_res, m_done, m_sel;
  int m_tyen, m_div, m_mode, m_unit;
  logic [15:0] m_en, m_trig, h1, h2, h3;
  int m_src [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_pre = 0; m_cnt = 0; m_res = 0; m_done = 0; m_sel = 0;
      m_tyen = 0; m_div = 0; m_mode = 0; m_unit = 0;
      m_en = '0; m_trig = '0; h1 = '0; h2 = '0; h3 = '0;
      foreach (m_src[c]) m_src[c] = 0;
    end else begin
      automatic logic [15:0] rise = h2 & ~h3;
      automatic logic [15:0] newb = '0;
      automatic int pick = -1;
      automatic bit tk = (m_state != 0) && (m_pre == (4 << (2 * m_div)) - 1);
      if (wr_en && wr_addr == 3'd4 && m_tyen == 1)
        newb = wr_data[15:0] & ~m_trig & m_en;
      for (int c = 15; c >= 0; c--) if (newb[c]) pick = c;
      if (pick >= 0) begin
        m_state = 1; m_sel = pick; m_cnt = 0; m_pre = 0; m_done = 0; m_res = 0;
      end else if (m_state != 0) begin
        if (rise[m_sel]) begin
          if (m_state == 1) begin m_state = 2; m_cnt = 0; m_pre = 0; end
          else begin m_state = 0; m_done = 1; m_res = m_cnt; end
        end else if (tk) begin
          m_pre = 0;
          if (m_cnt == CMAX - 1) begin m_state = 0; m_done = 1; m_res = CMAX; end
          else m_cnt++;
        end else m_pre++;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_en = wr_data[31:16];
          3'd1: begin
            m_tyen = int'(wr_data[0]); m_div = int'(wr_data[3:1]);
            m_mode = int'(wr_data[5:4]); m_unit = int'(wr_data[31:16]);
          end
          3'd2: for (int c = 0; c < 16; c++) m_src[c] = (m_src[c] & 4) | int'(wr_data[2*c +: 2]);
          3'd3: for (int c = 0; c < 16; c++) m_src[c] = (m_src[c] & 3) | (wr_data[2*c] ? 4 : 0);
          3'd4: m_trig = wr_data[15:0];
          default: ;
        endcase
      end
      h3 = h2; h2 = h1; h1 = tach;
    end
  end

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: v = {m_en, 16'h0};
      3'd1: v = (32'(m_unit) << 16) | (32'(m_mode) << 4) | (32'(m_div) << 1) | 32'(m_tyen);
      3'd2: for (int c = 0; c < 16; c++) v[2*c +: 2] = 2'(m_src[c] & 3);
      3'd3: for (int c = 0; c < 16; c++) v[2*c] = (m_src[c] & 4) != 0;
      3'd4: v = 32'(m_trig);
      3'd5: v = (m_done != 0 ? 32'h8000_0000 : 32'h0) | 32'(m_res);
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model (R2, R3, R9 read-back)
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) check("R9 per-clock read vs model", rd_data, exp_read(rd_addr));
  end

  // ---------------- tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_addr = a;
    @(posedge clk); #2; check(tag, rd_data, exp);
    @(negedge clk); rd_addr = 3'd5;
  endtask

  task automatic trigger(input logic [15:0] bits);
    wr(3'd4, 32'h0);
    wr(3'd4, 32'(bits));
  endtask

  task automatic wait_done(input int lim);
    for (int i = 0; i < lim; i++) begin
      @(posedge clk); #3;
      if (rd_data[31]) break;
    end
  endtask

  function automatic logic [31:0] done_word(input int cnt);
    return 32'h8000_0000 | 32'(cnt);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    foreach (hp[c]) hp[c] = 25;
    hp[1] = 0; hp[3] = 50; hp[5] = 300; hp[7] = 40; hp[9] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a < 6; a++) rd_check(3'(a), 32'h0, "R1 reset value");

    // R2 layout
    wr(3'd0, 32'hFFFF_FFFF);
    rd_check(3'd0, 32'hFFFF_0000, "R2 ctrl readback");
    wr(3'd1, 32'hFFFF_FFFF);
    rd_check(3'd1, 32'hFFFF_003F, "R2 type readback");

    // R3 source split: channel 2 tag 5, others tag 4
    wr(3'd2, 32'h0000_0010);
    wr(3'd3, 32'hFFFF_FFFF);
    rd_check(3'd2, 32'h0000_0010, "R3 src low word");
    rd_check(3'd3, 32'h5555_5555, "R3 src high word");

    // real setup: channels 3,5,9 enabled, div 0
    wr(3'd0, (32'd1 << 19) | (32'd1 << 21) | (32'd1 << 25));
    wr(3'd1, 32'h1);

    // R8 ch3 period 100, D=4 -> (99)/4 = 24
    trigger(16'h0008);
    wait_done(3000);
    rd_check(3'd5, done_word(24), "R8 ch3 D=4 count");

    // R4 re-writing the already-set bit starts nothing
    wr(3'd4, 32'h0008);
    repeat (300) @(negedge clk);
    rd_check(3'd5, done_word(24), "R4 no restart without clear");

    // R5 disabled channel 7
    trigger(16'h0080);
    repeat (300) @(negedge clk);
    rd_check(3'd5, done_word(24), "R5 disabled channel ignored");

    // R5 type disabled
    wr(3'd1, 32'h0);
    trigger(16'h0008);
    repeat (300) @(negedge clk);
    rd_check(3'd5, done_word(24), "R5 type disable ignored");
    wr(3'd1, 32'h1);

    // R6 bits 1 (disabled), 5, 9 -> ch5: 599/4 = 149
    trigger(16'h0222);
    wait_done(5000);
    rd_check(3'd5, done_word(149), "R6 lowest eligible channel");

    // R7 divider 1 (D=16) and 2 (D=64) on ch5
    wr(3'd1, 32'h3);
    trigger(16'h0020);
    wait_done(5000);
    rd_check(3'd5, done_word(37), "R7 D=16 count");
    wr(3'd1, 32'h5);
    trigger(16'h0020);
    wait_done(5000);
    rd_check(3'd5, done_word(9), "R7 D=64 count");

    // R12 mode and unit do not change the count
    wr(3'd1, 32'hABCD_0031);
    trigger(16'h0008);
    wait_done(3000);
    rd_check(3'd5, done_word(24), "R12 mode/unit no effect");
    wr(3'd1, 32'h1);

    // R10 stuck channel 9 saturates
    trigger(16'h0200);
    wait_done(8000);
    rd_check(3'd5, done_word(CMAX), "R10 saturation all-ones");

    // R11 start clears, restart mid-measurement onto ch3
    trigger(16'h0200);
    repeat (100) @(negedge clk);
    rd_check(3'd5, 32'h0, "R11 start clears done and count");
    wr(3'd4, 32'h0208);
    wait_done(3000);
    rd_check(3'd5, done_word(24), "R11 restart onto ch3");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule